// File: doc/BRIEF.md
# Serial Input Edge Event Detector

This block watches the input bytes that a serial I/O expander captures once per frame, and turns changes on them into sticky, per-pin event flags. The input pins come in groups of eight. Each time the shift engine reports a finished frame, the block compares the new byte of every group with the byte it captured on the previous frame. Pins whose transition matches their configured edge type set a status bit. That bit stays set until software clears it.

Software controls the block through a small byte/halfword register port. There is one 16-bit edge-select word per group, holding a 2-bit field for each pin, and one byte of write-one-to-clear status per group. A level interrupt request is the registered OR of all pending status bits in the groups that are currently configured as inputs.

The block sits between the frame-level shift engine and the bus fabric. It does no serial shifting itself.

Top module: `sio_edge_event`

## Requirements
- R1: After reset, every edge-select word, every status byte and the interrupt output are zero.
- R2: The edge-select word of group g is at byte address 0x10+2g, little-endian, and is readable and writable by byte or by aligned halfword. Pin p of the group uses bits [2p+1:2p]. A misaligned halfword access is ignored and reads as zero.
- R3: The 2-bit field value 0 selects no edge, 1 selects a low-to-high change, 2 a high-to-low change and 3 either change. On each frame-done strobe, a pin whose captured value changed in a selected direction since the previous frame sets its status bit.
- R4: The status of group g is the byte at address 0x20+g, with bit p for pin p. A set bit stays set until it is cleared.
- R5: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged, so writing 0xFF clears the whole group.
- R6: When a new edge and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R7: While the scan enable is low, frames are ignored. The first frame after the enable goes high (or after reset) only records the reference value and sets no status.
- R8: Only groups whose index is below the active input group count can set status bits.
- R9: The interrupt output goes high one cycle after any status bit of an active group is set, and returns low one cycle after no such bit remains.
- R10: A change to an edge-select field applies from the next frame comparison and leaves status that is already set untouched.
- R11: An aligned halfword write at status address 0x20+g applies its low byte as a clear mask to group g and its high byte to group g+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_en | input | 1 | Enables frame comparison; low drops the reference frame |
| in_grp_count | input | CNT_W | Number of groups, from group 0 up, that act as inputs |
| frame_done | input | 1 | One-cycle strobe: a new frame of input bytes is valid |
| frame_din | input | NUM_GROUPS*8 | Captured input bytes, group g in bits [8g+7:8g] |
| reg_wr | input | 1 | Register write strobe |
| reg_half | input | 1 | 1 = halfword access, 0 = byte access |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 16 | Write data; a byte access uses bits [7:0] |
| reg_rdata | output | 16 | Read data for reg_addr (combinational, zero-extended for bytes) |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench aims at the sticky-versus-clear race: it strikes an edge and a one-clear on the same bit in one cycle. A design that gives the clear priority would return that bit as zero. It also disables and re-enables scanning between two frames of different value, which catches a design that keeps the stale reference and flags phantom edges on the first frame. Halfword status writes, zero-mask writes and edge-select rewrites are all checked against status bits that are already set. These catch lane swaps, clear-on-zero bugs and configuration writes that wipe pending events. Finally, the active group count is shrunk while events are pending, and the interrupt is sampled on the cycle status sets, to expose an unmasked or unregistered request.

// File: rtl/sio_evt_pkg.sv
// Package: shared constants, the edge-select encoding and the per-pin edge test.
// Assumes each group is eight pins wide and addresses fit in eight bits.
package sio_evt_pkg;

    localparam int GRP_BITS = 8;
    localparam int CFG_W    = 16;
    localparam int CFG_BASE = 'h10;
    localparam int STS_BASE = 'h20;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    // True when the old-to-new change matches the selected edge type.
    function automatic logic edge_hit(input edge_sel_e sel, input logic old_v, input logic new_v);
        logic rise_ok;
        logic fall_ok;
        rise_ok = (sel == EDGE_RISE) || (sel == EDGE_BOTH);
        fall_ok = (sel == EDGE_FALL) || (sel == EDGE_BOTH);
        return (rise_ok && !old_v && new_v) || (fall_ok && old_v && !new_v);
    endfunction

endpackage

// File: rtl/sio_evt_detect.sv
// Edge detector: holds the previous frame's input bytes and, on each frame
// strobe, flags per-pin edges that match the configured edge type.
// Assumes frame_done is a single-cycle strobe. The hit vector is combinational.
module sio_evt_detect
    import sio_evt_pkg::*;
#(
    parameter  int NUM_GROUPS = 8,
    localparam int NB         = NUM_GROUPS * GRP_BITS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scan_en,
    input  logic                        frame_done,
    input  logic [NB-1:0]               frame_din,
    input  logic [NUM_GROUPS*CFG_W-1:0] cfg_flat,
    input  logic [NUM_GROUPS-1:0]       grp_active,
    output logic [NB-1:0]               hit
);

    logic [NB-1:0] prev_q;
    logic          ref_q;
    logic          cmp_en;

    // Track the reference frame; dropping the enable invalidates it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            ref_q  <= 1'b0;
        end else if (!scan_en) begin
            ref_q  <= 1'b0;
        end else if (frame_done) begin
            prev_q <= frame_din;
            ref_q  <= 1'b1;
        end
    end

    assign cmp_en = scan_en && frame_done && ref_q;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        for (genvar p = 0; p < GRP_BITS; p++) begin : g_pin
            // Per-pin edge match, gated by comparison enable and group role.
            assign hit[g*GRP_BITS+p] = cmp_en && grp_active[g] &&
                edge_hit(edge_sel_e'(cfg_flat[g*CFG_W+2*p +: 2]),
                         prev_q[g*GRP_BITS+p], frame_din[g*GRP_BITS+p]);
        end
    end

endmodule

// File: rtl/sio_evt_regs.sv
// Register file: edge-select words and write-one-to-clear status bytes,
// with byte and aligned-halfword access. Read data is combinational.
// Assumes 0x10+2*NUM_GROUPS <= 0x20 so the two regions do not overlap.
module sio_evt_regs
    import sio_evt_pkg::*;
#(
    parameter  int NUM_GROUPS = 8,
    parameter  int ADDR_W     = 8,
    localparam int NB         = NUM_GROUPS * GRP_BITS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic                        reg_half,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [15:0]                 reg_wdata,
    input  logic [NB-1:0]               hit,
    output logic [NUM_GROUPS*CFG_W-1:0] cfg_flat,
    output logic [NB-1:0]               sts_flat,
    output logic [15:0]                 reg_rdata
);

    // Byte address of configuration byte b of group g.
    function automatic logic [ADDR_W-1:0] cfg_addr(input int g, input int b);
        return ADDR_W'(CFG_BASE + 2 * g + b);
    endfunction

    // Byte address of the status byte of group g.
    function automatic logic [ADDR_W-1:0] sts_addr(input int g);
        return ADDR_W'(STS_BASE + g);
    endfunction

    // Returns {enable, data} for a write landing on byte address target.
    function automatic logic [8:0] lane_write(input logic [ADDR_W-1:0] target,
                                              input logic wr, input logic half,
                                              input logic [ADDR_W-1:0] addr,
                                              input logic [15:0] wd);
        logic [ADDR_W-1:0] nxt;
        nxt = addr + ADDR_W'(1);
        if (wr && (addr == target) && (!half || !addr[0]))
            return {1'b1, wd[7:0]};
        if (wr && half && !addr[0] && (nxt == target))
            return {1'b1, wd[15:8]};
        return 9'd0;
    endfunction

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic [CFG_W-1:0]    cfg_q;
        logic [GRP_BITS-1:0] sts_q;
        logic [8:0]          cw_lo;
        logic [8:0]          cw_hi;
        logic [8:0]          sw;
        logic [GRP_BITS-1:0] clr;

        assign cw_lo = lane_write(cfg_addr(g, 0), reg_wr, reg_half, reg_addr, reg_wdata);
        assign cw_hi = lane_write(cfg_addr(g, 1), reg_wr, reg_half, reg_addr, reg_wdata);
        assign sw    = lane_write(sts_addr(g),    reg_wr, reg_half, reg_addr, reg_wdata);
        assign clr   = sw[8] ? sw[7:0] : '0;

        // Edge-select word: byte-lane writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q <= '0;
            end else begin
                if (cw_lo[8]) cfg_q[7:0]  <= cw_lo[7:0];
                if (cw_hi[8]) cfg_q[15:8] <= cw_hi[7:0];
            end
        end

        // Status byte: clear by ones, new edges win over a same-cycle clear.
        always_ff @(posedge clk) begin
            if (!rst_n) sts_q <= '0;
            else        sts_q <= (sts_q & ~clr) | hit[g*GRP_BITS +: GRP_BITS];
        end

        assign cfg_flat[g*CFG_W +: CFG_W]       = cfg_q;
        assign sts_flat[g*GRP_BITS +: GRP_BITS] = sts_q;
    end

    logic [ADDR_W-1:0] hi_addr;
    logic [7:0]        lo_byte;
    logic [7:0]        hi_byte;

    // Read mux: look up the addressed byte and, for halfwords, the next one.
    always_comb begin
        hi_addr = reg_addr + ADDR_W'(1);
        lo_byte = '0;
        hi_byte = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            for (int b = 0; b < 2; b++) begin
                if (reg_addr == cfg_addr(g, b)) lo_byte = cfg_flat[g*CFG_W + 8*b +: 8];
                if (hi_addr  == cfg_addr(g, b)) hi_byte = cfg_flat[g*CFG_W + 8*b +: 8];
            end
            if (reg_addr == sts_addr(g)) lo_byte = sts_flat[g*GRP_BITS +: GRP_BITS];
            if (hi_addr  == sts_addr(g)) hi_byte = sts_flat[g*GRP_BITS +: GRP_BITS];
        end
        reg_rdata = {(reg_half && !reg_addr[0]) ? hi_byte : 8'h00,
                     (!reg_half || !reg_addr[0]) ? lo_byte : 8'h00};
    end

endmodule

// File: rtl/sio_evt_irq.sv
// Interrupt generator: registered OR of status bits of the active groups.
// Assumes grp_active is stable enough that a one-cycle lag is acceptable.
module sio_evt_irq
    import sio_evt_pkg::*;
#(
    parameter  int NUM_GROUPS = 8,
    localparam int NB         = NUM_GROUPS * GRP_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NB-1:0]         sts_flat,
    input  logic [NUM_GROUPS-1:0] grp_active,
    output logic                  irq
);

    logic [NB-1:0] masked;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_mask
        assign masked[g*GRP_BITS +: GRP_BITS] = sts_flat[g*GRP_BITS +: GRP_BITS] & {GRP_BITS{grp_active[g]}};
    end

    // Register the request so it leaves the block glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |masked;
    end

endmodule

// File: rtl/sio_edge_event.sv
// Top level: serial input edge event detector. Groups below in_grp_count
// act as inputs; the rest never raise events or interrupts.
// Assumes NUM_GROUPS <= 8 so the register map fits 0x10..0x27.
module sio_edge_event
    import sio_evt_pkg::*;
#(
    parameter  int NUM_GROUPS = 8,
    parameter  int ADDR_W     = 8,
    localparam int CNT_W      = $clog2(NUM_GROUPS + 1),
    localparam int NB         = NUM_GROUPS * GRP_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic [CNT_W-1:0]  in_grp_count,
    input  logic              frame_done,
    input  logic [NB-1:0]     frame_din,
    input  logic              reg_wr,
    input  logic              reg_half,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              irq
);

    logic [NUM_GROUPS-1:0]       grp_active;
    logic [NUM_GROUPS*CFG_W-1:0] cfg_flat;
    logic [NB-1:0]               sts_flat;
    logic [NB-1:0]               hit;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_act
        // A group is an input when its index is below the configured count.
        assign grp_active[g] = (in_grp_count > CNT_W'(g));
    end

    sio_evt_detect #(.NUM_GROUPS(NUM_GROUPS)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_en    (scan_en),
        .frame_done (frame_done),
        .frame_din  (frame_din),
        .cfg_flat   (cfg_flat),
        .grp_active (grp_active),
        .hit        (hit)
    );

    sio_evt_regs #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_half  (reg_half),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .hit       (hit),
        .cfg_flat  (cfg_flat),
        .sts_flat  (sts_flat),
        .reg_rdata (reg_rdata)
    );

    sio_evt_irq #(.NUM_GROUPS(NUM_GROUPS)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sts_flat   (sts_flat),
        .grp_active (grp_active),
        .irq        (irq)
    );

endmodule

// File: rtl/sio_edge_event_chk.sv
// Checker: temporal properties of status and interrupt, bound to the top.
module sio_edge_event_chk #(
    parameter  int NUM_GROUPS = 8,
    localparam int NB         = NUM_GROUPS * 8,
    localparam int CNT_W      = $clog2(NUM_GROUPS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_done,
    input logic             reg_wr,
    input logic [CNT_W-1:0] in_grp_count,
    input logic [NB-1:0]    sts_flat,
    input logic             irq
);

    logic [NB-1:0] act_bits;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_act
        assign act_bits[g*8 +: 8] = {8{in_grp_count > CNT_W'(g)}};
    end

    // R4: with no register write, no set status bit is lost.
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((sts_flat & $past(sts_flat)) == $past(sts_flat)));

    // R3: status bits are only set by a frame comparison.
    a_r3_set_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> ((sts_flat & ~$past(sts_flat)) == '0));

    // R8: groups outside the active count never gain a status bit.
    a_r8_inactive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> ((sts_flat & ~$past(sts_flat) & ~$past(act_bits)) == '0));

    // R9: the request is low one cycle after no active status was pending.
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_flat & act_bits) == '0) |=> !irq);

    // R9: the request is high one cycle after an active status was pending.
    a_r9_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_flat & act_bits) != '0) |=> irq);

endmodule

bind sio_edge_event sio_edge_event_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_done   (frame_done),
    .reg_wr       (reg_wr),
    .in_grp_count (in_grp_count),
    .sts_flat     (sts_flat),
    .irq          (irq)
);

// File: tb/sio_edge_event_bench.sv
`timescale 1ns/1ps
module sio_edge_event_bench;

    localparam int NG = 8;
    localparam int NB = NG * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_en = 1'b0;
    logic [3:0]    in_grp_count = '0;
    logic          frame_done = 1'b0;
    logic [NB-1:0] frame_din = '0;
    logic          reg_wr = 1'b0;
    logic          reg_half = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          irq;

    always #10 clk = ~clk;

    sio_edge_event #(.NUM_GROUPS(NG)) u_sio_edge_event (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .in_grp_count(in_grp_count),
        .frame_done(frame_done), .frame_din(frame_din), .reg_wr(reg_wr),
        .reg_half(reg_half), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // Reference model, built from the requirements.
    logic [15:0]   m_cfg [NG];
    logic [7:0]    m_sts [NG];
    logic [NB-1:0] m_prev = '0;
    bit            m_ref = 0;
    bit            m_en  = 0;
    int            m_cnt = 0;

    // Scoreboard queues: kind 0 = read data, kind 1 = irq.
    int          kind_q [$];
    logic [15:0] exp_q  [$];
    string       tag_q  [$];
    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 0;

    function automatic logic model_irq();
        logic r = 1'b0;
        for (int g = 0; g < NG; g++) if (g < m_cnt && m_sts[g] != 0) r = 1'b1;
        return r;
    endfunction

    function automatic void model_byte(input logic [7:0] a, input logic [7:0] d);
        if (a >= 8'h10 && a < 8'h20) begin
            if (a[0]) m_cfg[(a - 8'h10) >> 1][15:8] = d;
            else      m_cfg[(a - 8'h10) >> 1][7:0]  = d;
        end else if (a >= 8'h20 && a < 8'h28) begin
            m_sts[a - 8'h20] = m_sts[a - 8'h20] & ~d;
        end
    endfunction

    function automatic void model_wr(input logic [7:0] a, input logic h, input logic [15:0] d);
        if (!h) model_byte(a, d[7:0]);
        else if (!a[0]) begin
            model_byte(a, d[7:0]);
            model_byte(a + 8'd1, d[15:8]);
        end
    endfunction

    function automatic void model_frame(input logic [NB-1:0] d);
        if (!m_en) return;
        if (m_ref) begin
            for (int g = 0; g < NG; g++) begin
                if (g < m_cnt) begin
                    for (int p = 0; p < 8; p++) begin
                        logic [1:0] sel;
                        logic o;
                        logic n;
                        sel = m_cfg[g][2*p +: 2];
                        o = m_prev[g*8+p];
                        n = d[g*8+p];
                        if ((sel[0] && !o && n) || (sel[1] && o && !n)) m_sts[g][p] = 1'b1;
                    end
                end
            end
        end
        m_prev = d;
        m_ref = 1;
    endfunction

    // Monitor: pops one expected item per cycle and compares after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                int k;
                logic [15:0] e;
                logic [15:0] act;
                string t;
                k = kind_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                act = (k == 1) ? {15'd0, irq} : reg_rdata;
                n_chk++;
                if (act !== e) begin
                    n_err++;
                    $display("FAIL %s: actual %h expected %h", t, act, e);
                end
            end
        end
    end

    task automatic push(input int k, input logic [15:0] e, input string t);
        kind_q.push_back(k);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic h, input logic [15:0] e, input string t);
        @(negedge clk);
        reg_addr = a;
        reg_half = h;
        push(0, e, t);
    endtask

    task automatic irq_chk(input string t);
        @(negedge clk);
        push(1, {15'd0, model_irq()}, t);
    endtask

    task automatic sts_all(input string t);
        for (int g = 0; g < NG; g++) rd_chk(8'h20 + 8'(g), 1'b0, {8'h00, m_sts[g]}, t);
    endtask

    task automatic wr(input logic [7:0] a, input logic h, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_half = h; reg_wdata = d;
        model_wr(a, h, d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic frame(input logic [NB-1:0] d);
        @(negedge clk);
        frame_done = 1'b1; frame_din = d;
        model_frame(d);
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    // Frame with an interrupt sample on the cycle status sets (R9 lag).
    task automatic frame_lag(input logic [NB-1:0] d);
        @(negedge clk);
        frame_done = 1'b1; frame_din = d;
        push(1, {15'd0, model_irq()}, "R9 irq lags status by one cycle");
        model_frame(d);
        @(negedge clk);
        frame_done = 1'b0;
        reg_addr = 8'h20; reg_half = 1'b0;
        push(0, {8'h00, m_sts[0]}, "R3 status set on frame edge");
    endtask

    task automatic frame_and_clear(input logic [NB-1:0] d, input logic [7:0] a, input logic [7:0] c);
        @(negedge clk);
        frame_done = 1'b1; frame_din = d;
        reg_wr = 1'b1; reg_addr = a; reg_half = 1'b0; reg_wdata = {8'h00, c};
        model_wr(a, 1'b0, {8'h00, c});
        model_frame(d);
        @(negedge clk);
        frame_done = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        scan_en = v;
        m_en = v;
        if (!v) m_ref = 0;
    endtask

    task automatic set_cnt(input int c);
        @(negedge clk);
        in_grp_count = 4'(c);
        m_cnt = c;
    endtask

    task automatic clear_all();
        for (int g = 0; g < NG; g += 2) wr(8'h20 + 8'(g), 1'b1, 16'hFFFF);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20ns * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int g = 0; g < NG; g++) begin
            m_cfg[g] = '0;
            m_sts[g] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        for (int g = 0; g < NG; g++) rd_chk(8'h10 + 8'(2*g), 1'b1, 16'h0000, "R1 cfg reset");
        sts_all("R1 status reset");
        irq_chk("R1 irq reset");

        set_cnt(6);

        // R2/R3: edge-select words, one encoding per group.
        wr(8'h10, 1'b1, 16'h5555);
        wr(8'h12, 1'b1, 16'hAAAA);
        wr(8'h14, 1'b1, 16'hFFFF);
        wr(8'h16, 1'b1, 16'hE4E4);
        wr(8'h18, 1'b0, 16'h0099);
        wr(8'h19, 1'b0, 16'h0066);
        wr(8'h1C, 1'b1, 16'hFFFF);
        wr(8'h1E, 1'b1, 16'hFFFF);
        wr(8'h1B, 1'b1, 16'h1234);
        rd_chk(8'h18, 1'b1, 16'h6699, "R2 halfword readback");
        rd_chk(8'h19, 1'b0, 16'h0066, "R2 high byte read");
        rd_chk(8'h16, 1'b0, 16'h00E4, "R2 low byte read");
        rd_chk(8'h1A, 1'b1, 16'h0000, "R2 misaligned write ignored");
        rd_chk(8'h13, 1'b1, 16'h0000, "R2 misaligned read zero");
        rd_chk(8'h10, 1'b1, m_cfg[0], "R2 group0 word");

        // R7: first frame after enable only sets the reference.
        set_en(1'b1);
        frame({NG{8'h00}});
        sts_all("R7 first frame no status");
        irq_chk("R7 irq quiet after first frame");

        // R3/R8/R9: all pins rise.
        frame_lag({NG{8'hFF}});
        irq_chk("R9 irq raised");
        sts_all("R3 rise patterns");
        rd_chk(8'h26, 1'b0, 16'h0000, "R8 inactive group 6 no status");
        rd_chk(8'h27, 1'b0, 16'h0000, "R8 inactive group 7 no status");
        rd_chk(8'h20, 1'b1, {m_sts[1], m_sts[0]}, "R4 halfword status read");

        // R5/R11: clear semantics.
        wr(8'h20, 1'b0, 16'h0000);
        rd_chk(8'h20, 1'b0, {8'h00, m_sts[0]}, "R5 zero write keeps bits");
        wr(8'h20, 1'b0, 16'h000F);
        rd_chk(8'h20, 1'b0, {8'h00, m_sts[0]}, "R5 partial clear");
        wr(8'h24, 1'b0, 16'h00FF);
        rd_chk(8'h24, 1'b0, 16'h0000, "R5 clear all of a group");
        wr(8'h22, 1'b1, 16'h0F00);
        rd_chk(8'h22, 1'b0, {8'h00, m_sts[2]}, "R11 low byte to group 2");
        rd_chk(8'h23, 1'b0, {8'h00, m_sts[3]}, "R11 high byte to group 3");

        // R3/R4: all pins fall, earlier bits stay.
        frame({NG{8'h00}});
        sts_all("R3 fall patterns");

        // R10: config change keeps pending status and applies next frame.
        wr(8'h12, 1'b1, 16'h0000);
        rd_chk(8'h21, 1'b0, {8'h00, m_sts[1]}, "R10 config write keeps status");
        wr(8'h21, 1'b0, 16'h00FF);
        frame({NG{8'hFF}});
        frame({NG{8'h00}});
        rd_chk(8'h21, 1'b0, {8'h00, m_sts[1]}, "R10 disabled field no event");
        wr(8'h12, 1'b1, 16'h5555);
        frame({NG{8'hFF}});
        rd_chk(8'h21, 1'b0, {8'h00, m_sts[1]}, "R10 new field used next frame");

        // R6: edge and clear on the same bit in one cycle.
        clear_all();
        frame({NG{8'h00}});
        frame_and_clear({NG{8'hFF}}, 8'h20, 8'hFF);
        rd_chk(8'h20, 1'b0, {8'h00, m_sts[0]}, "R6 set wins over clear");
        sts_all("R6 other groups");

        // R9: request drops once everything is cleared.
        clear_all();
        irq_chk("R9 irq low after clear");

        // R7: disabled scanning ignores frames; re-enable needs a new reference.
        set_en(1'b0);
        frame({NG{8'h00}});
        sts_all("R7 disabled frame ignored");
        set_en(1'b1);
        frame({NG{8'h00}});
        sts_all("R7 re-enable first frame no status");
        frame({NG{8'hFF}});
        sts_all("R7 second frame compares");

        // R8/R9: shrink the input group count with events pending.
        set_cnt(2);
        wr(8'h20, 1'b1, 16'hFFFF);
        irq_chk("R8 irq ignores inactive groups");
        frame({NG{8'h00}});
        sts_all("R8 only active groups set");
        irq_chk("R9 irq from active group");

        repeat (4) @(negedge clk);
        done = 1;
        finish_run();
    end

endmodule